// File: doc/BRIEF.md
# Sync-Mode Frame Length Adjuster

This block keeps a transmitted frame stream locked to an external synchronisation period. At the end of each sync cycle, the measuring logic supplies the time that the variable-length tail window of the frame really took. The block then recomputes how long that tail window must be and how many six-bit stuffing blocks the frame carries. The sync period may hold 1 to 10 frames and run at 8 kHz to 50 kHz, so the remainder that has to be absorbed changes from cycle to cycle.

All times are counted in sub-bit units, one eighth of a bit by default. The window size is held as its bit count minus one. The fractional part of the new window becomes a one-byte sample pattern for the transmit FIFO, and that pattern places the final edge inside the last bit. When the whole-bit window size leaves the allowed band, the block swaps one stuffing block against six bits of window. This swap keeps the total frame time unchanged and brings the size back into the band.

The caller presents the current state and the measured time and raises a one-cycle update strobe. One clock later the new state appears, together with a one-cycle done pulse. The caller feeds that state back in on the next update.

Top module: `sync_frame_adjust`

## Requirements
- R1: While reset is asserted, and after it is released before any update, every output reads zero and `done_o` is low.
- R2: Outputs take their new values on the clock edge that samples `upd_i` high, and `done_o` is high for exactly the cycle after that edge. With `upd_i` low, every output holds its value and `done_o` is low.
- R3: If the edge pattern of the incoming residual is zero (that is, `res_i` is 8 or more), 8 is added to the residual before the update arithmetic.
- R4: With r the residual after R3, let s = r + `win_i` - 8. The raw new size is floor(s / 8), computed as an arithmetic right shift by 3. The new residual `res_o` is s minus 8 times the raw size, so it always lies in 0..7.
- R5: A raw size below 3 is raised by 6. In the same update `win_o` becomes `win_i` + 48 and the stuffing count drops by one.
- R6: A raw size above 8 is lowered by 6. In the same update `win_o` becomes `win_i` - 48 and the stuffing count rises by one.
- R7: A raw size in 3..8 passes through unchanged. `win_o` equals `win_i` and `stuff_o` equals `stuff_i`.
- R8: The stuffing count saturates at 0 and at MAX_STUFF (default 60) instead of wrapping. In that case the size and window adjustments of R5 and R6 still take place.
- R9: `edge_o` bit i is 1 exactly when i >= `res_o`, with bit 7 the most significant. A residual of 4 gives 0xF0 and a residual of 0 gives 0xFF.
- R10: `size_i` has no effect on any output, because it appears in both terms of the difference and cancels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | One-cycle strobe at the end of a sync cycle |
| win_i | input | DW (16) | Measured tail-window time, signed, sub-bit units |
| size_i | input | DW (16) | Current tail-window size (bits minus one), signed |
| res_i | input | DW (16) | Current residual time, signed, sub-bit units |
| stuff_i | input | STUFF_W (8) | Current number of stuffing blocks |
| size_o | output | DW (16) | New tail-window size (bits minus one) |
| res_o | output | DW (16) | New residual, 0..7 |
| stuff_o | output | STUFF_W (8) | New stuffing block count |
| win_o | output | DW (16) | New tail-window time |
| edge_o | output | EDGE_W (8) | Sample pattern for the final edge |
| done_o | output | 1 | High for one cycle when the new values are valid |

## Verification
A wrong fold decision, shift or remainder shows up on `res_o` and `edge_o` on the done cycle of the very update that uses it. A misplaced band threshold shows up on `size_o` and on a window value that is 48 off, also on that same done cycle. Saturation faults appear only when the count starts at 0 or at its ceiling, so the sweep includes both of those starting counts. Because each update depends only on its own inputs, a corrupted register can never hide until a later cycle. A stuck or missing strobe path is visible in the very next cycle as a `done_o` pulse that is absent or extra.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
   typedef enum logic [1:0] {
      TRADE_HOLD   = 2'd0,
      TRADE_GROW   = 2'd1,
      TRADE_SHRINK = 2'd2
   } trade_e;
endpackage

// File: rtl/sfl_edge_gen.sv
module sfl_edge_gen #(
   parameter int DW     = 16,
   parameter int EDGE_W = 8
) (
   input  logic signed [DW-1:0] res_i,
   output logic [EDGE_W-1:0]    pat_o
);
   for (genvar i = 0; i < EDGE_W; i++) begin : g_bit
      localparam logic signed [DW-1:0] POS = DW'(i);
      assign pat_o[i] = (res_i <= POS);
   end
endmodule

// File: rtl/sfl_window_calc.sv
module sfl_window_calc #(
   parameter int DW     = 16,
   parameter int EDGE_W = 8
) (
   input  logic                 fold_i,
   input  logic signed [DW-1:0] win_i,
   input  logic signed [DW-1:0] size_i,
   input  logic signed [DW-1:0] res_i,
   output logic signed [DW-1:0] raw_size_o,
   output logic signed [DW-1:0] raw_res_o
);
   localparam int FRAC_W = $clog2(EDGE_W);
   localparam logic signed [DW-1:0] UNIT = DW'(EDGE_W);

   logic signed [DW-1:0] res_adj;
   logic signed [DW-1:0] whole;
   logic signed [DW-1:0] span_b;
   logic signed [DW-1:0] span_oh;
   logic signed [DW-1:0] diff;

   always_comb begin
      res_adj    = fold_i ? res_i + UNIT : res_i;
      whole      = size_i <<< FRAC_W;
      span_b     = whole + res_adj;
      span_oh    = whole + UNIT - win_i;
      diff       = span_b - span_oh;
      raw_size_o = diff >>> FRAC_W;
      raw_res_o  = diff - (raw_size_o <<< FRAC_W);
   end
endmodule

// File: rtl/sfl_trade.sv
module sfl_trade
   import sfl_pkg::*;
#(
   parameter int DW         = 16,
   parameter int EDGE_W     = 8,
   parameter int STUFF_W    = 8,
   parameter int MAX_STUFF  = 60,
   parameter int SIZE_LO    = 3,
   parameter int SIZE_HI    = 8,
   parameter int BLOCK_BITS = 6
) (
   input  logic signed [DW-1:0] size_i,
   input  logic signed [DW-1:0] win_i,
   input  logic [STUFF_W-1:0]   stuff_i,
   output logic signed [DW-1:0] size_o,
   output logic signed [DW-1:0] win_o,
   output logic [STUFF_W-1:0]   stuff_o
);
   localparam logic signed [DW-1:0] LO_S  = DW'(SIZE_LO);
   localparam logic signed [DW-1:0] HI_S  = DW'(SIZE_HI);
   localparam logic signed [DW-1:0] SPAN  = DW'(BLOCK_BITS);
   localparam logic signed [DW-1:0] WSTEP = DW'(BLOCK_BITS * EDGE_W);
   localparam logic [STUFF_W-1:0]   SMAX  = STUFF_W'(MAX_STUFF);
   localparam logic [STUFF_W-1:0]   ONE   = STUFF_W'(1);

   trade_e sel;
   logic   at_min;
   logic   at_max;

   assign at_min = (stuff_i == '0);

   if (MAX_STUFF == (1 << STUFF_W) - 1) begin : g_full_range
      assign at_max = &stuff_i;
   end else begin : g_limit
      assign at_max = (stuff_i >= SMAX);
   end

   always_comb begin
      if (size_i < LO_S)      sel = TRADE_GROW;
      else if (size_i > HI_S) sel = TRADE_SHRINK;
      else                    sel = TRADE_HOLD;
   end

   always_comb begin
      size_o  = size_i;
      win_o   = win_i;
      stuff_o = stuff_i;
      case (sel)
         TRADE_GROW: begin
            size_o = size_i + SPAN;
            win_o  = win_i + WSTEP;
            if (!at_min) stuff_o = stuff_i - ONE;
         end
         TRADE_SHRINK: begin
            size_o = size_i - SPAN;
            win_o  = win_i - WSTEP;
            if (!at_max) stuff_o = stuff_i + ONE;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sync_frame_adjust.sv
module sync_frame_adjust #(
   parameter int DW         = 16,
   parameter int EDGE_W     = 8,
   parameter int STUFF_W    = 8,
   parameter int MAX_STUFF  = 60,
   parameter int SIZE_LO    = 3,
   parameter int SIZE_HI    = 8,
   parameter int BLOCK_BITS = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 upd_i,
   input  logic signed [DW-1:0] win_i,
   input  logic signed [DW-1:0] size_i,
   input  logic signed [DW-1:0] res_i,
   input  logic [STUFF_W-1:0]   stuff_i,
   output logic signed [DW-1:0] size_o,
   output logic signed [DW-1:0] res_o,
   output logic [STUFF_W-1:0]   stuff_o,
   output logic signed [DW-1:0] win_o,
   output logic [EDGE_W-1:0]    edge_o,
   output logic                 done_o
);
   localparam int FRAC_W = $clog2(EDGE_W);

   if (EDGE_W != (1 << FRAC_W) || EDGE_W < 2) begin : g_bad_edge
      $error("EDGE_W must be a power of two of at least 2");
   end
   if (SIZE_HI - SIZE_LO + 1 < BLOCK_BITS) begin : g_bad_band
      $error("size band narrower than one stuffing block");
   end
   if (MAX_STUFF < 1 || MAX_STUFF > (1 << STUFF_W) - 1) begin : g_bad_max
      $error("MAX_STUFF does not fit STUFF_W");
   end
   if (DW < 8) begin : g_bad_dw
      $error("DW too small");
   end

   logic [EDGE_W-1:0]    cur_pat;
   logic                 fold;
   logic signed [DW-1:0] raw_size;
   logic signed [DW-1:0] raw_res;
   logic signed [DW-1:0] nxt_size;
   logic signed [DW-1:0] nxt_win;
   logic [STUFF_W-1:0]   nxt_stuff;
   logic [EDGE_W-1:0]    nxt_pat;

   sfl_edge_gen #(.DW(DW), .EDGE_W(EDGE_W)) cur_edge_i (
      .res_i (res_i),
      .pat_o (cur_pat)
   );

   assign fold = (cur_pat == '0);

   sfl_window_calc #(.DW(DW), .EDGE_W(EDGE_W)) calc_i (
      .fold_i     (fold),
      .win_i      (win_i),
      .size_i     (size_i),
      .res_i      (res_i),
      .raw_size_o (raw_size),
      .raw_res_o  (raw_res)
   );

   sfl_trade #(
      .DW(DW), .EDGE_W(EDGE_W), .STUFF_W(STUFF_W), .MAX_STUFF(MAX_STUFF),
      .SIZE_LO(SIZE_LO), .SIZE_HI(SIZE_HI), .BLOCK_BITS(BLOCK_BITS)
   ) trade_i (
      .size_i  (raw_size),
      .win_i   (win_i),
      .stuff_i (stuff_i),
      .size_o  (nxt_size),
      .win_o   (nxt_win),
      .stuff_o (nxt_stuff)
   );

   sfl_edge_gen #(.DW(DW), .EDGE_W(EDGE_W)) nxt_edge_i (
      .res_i (raw_res),
      .pat_o (nxt_pat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         size_o  <= '0;
         res_o   <= '0;
         stuff_o <= '0;
         win_o   <= '0;
         edge_o  <= '0;
         done_o  <= 1'b0;
      end else begin
         done_o <= upd_i;
         if (upd_i) begin
            size_o  <= nxt_size;
            res_o   <= raw_res;
            stuff_o <= nxt_stuff;
            win_o   <= nxt_win;
            edge_o  <= nxt_pat;
         end
      end
   end
endmodule

// File: rtl/sync_frame_adjust_chk.sv
module sync_frame_adjust_chk #(
   parameter int DW         = 16,
   parameter int EDGE_W     = 8,
   parameter int STUFF_W    = 8,
   parameter int MAX_STUFF  = 60,
   parameter int BLOCK_BITS = 6
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 upd_i,
   input logic signed [DW-1:0] win_i,
   input logic [STUFF_W-1:0]   stuff_i,
   input logic signed [DW-1:0] size_o,
   input logic signed [DW-1:0] res_o,
   input logic [STUFF_W-1:0]   stuff_o,
   input logic signed [DW-1:0] win_o,
   input logic [EDGE_W-1:0]    edge_o,
   input logic                 done_o
);
   localparam logic signed [DW-1:0] WSTEP = DW'(BLOCK_BITS * EDGE_W);
   localparam logic signed [DW-1:0] UNIT  = DW'(EDGE_W);

   // R2
   done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      upd_i |=> done_o);

   // R2
   no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> !done_o);

   // R2
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_i |=> ($stable(size_o) && $stable(res_o) && $stable(stuff_o)
                  && $stable(win_o) && $stable(edge_o)));

   // R4
   res_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (res_o >= 0 && res_o < UNIT));

   // R9
   edge_matches_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($countones(edge_o) == EDGE_W - int'(res_o)));

   // R5 R6 R7
   win_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (win_o == $past(win_i)
                  || win_o == DW'($past(win_i) + WSTEP)
                  || win_o == DW'($past(win_i) - WSTEP)));

   // R8
   stuff_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(stuff_i) <= STUFF_W'(MAX_STUFF)) |-> stuff_o <= STUFF_W'(MAX_STUFF));

   // R5 R6
   stuff_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (stuff_o == $past(stuff_i)
                  || int'(stuff_o) == int'($past(stuff_i)) + 1
                  || int'(stuff_o) + 1 == int'($past(stuff_i))));
endmodule

bind sync_frame_adjust sync_frame_adjust_chk #(
   .DW(DW), .EDGE_W(EDGE_W), .STUFF_W(STUFF_W), .MAX_STUFF(MAX_STUFF),
   .BLOCK_BITS(BLOCK_BITS)
) chk_i (
   .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .win_i(win_i), .stuff_i(stuff_i),
   .size_o(size_o), .res_o(res_o), .stuff_o(stuff_o), .win_o(win_o),
   .edge_o(edge_o), .done_o(done_o)
);

// File: tb/sync_frame_adjust_tb_top.sv
module sync_frame_adjust_tb_top;
   localparam int DW = 16;
   localparam int SW = 8;
   localparam int MAXS = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic upd = 1'b0;
   logic signed [DW-1:0] win = '0, size = '0, res = '0;
   logic [SW-1:0] stuff = '0;
   logic signed [DW-1:0] size_o, res_o, win_o;
   logic [SW-1:0] stuff_o;
   logic [7:0] edge_o;
   logic done_o;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   sync_frame_adjust #(.DW(DW), .STUFF_W(SW), .MAX_STUFF(MAXS)) dut_i (
      .clk(clk), .rst_n(rst_n), .upd_i(upd), .win_i(win), .size_i(size),
      .res_i(res), .stuff_i(stuff), .size_o(size_o), .res_o(res_o),
      .stuff_o(stuff_o), .win_o(win_o), .edge_o(edge_o), .done_o(done_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   task automatic run_vec(input int r_in, input int w_in, input int sz_in, input int st_in,
                          input bit idle_check);
      int r, s, ns, nr, nw, nst, e;
      string zt, tag;
      r = r_in;
      if (r >= 8) r += 8;                 // R3 fold
      s  = r + w_in - 8;                  // R4
      ns = s >>> 3;
      nr = s - ns * 8;
      nw = w_in;
      nst = st_in;
      tag = "R7";
      if (ns < 3) begin                   // R5
         ns += 6; nw += 48; tag = "R5";
         nst = (st_in == 0) ? 0 : st_in - 1;
      end else if (ns > 8) begin          // R6
         ns -= 6; nw -= 48; tag = "R6";
         nst = (st_in == MAXS) ? MAXS : st_in + 1;
      end
      e = (8'hFF << nr) & 8'hFF;          // R9
      @(negedge clk);
      win = DW'(w_in); res = DW'(r_in); size = DW'(sz_in); stuff = SW'(st_in);
      upd = 1'b1;
      @(negedge clk);
      upd = 1'b0;
      check(done_o === 1'b1, "R2 done", int'(done_o), 1);
      zt = (sz_in != 0) ? "R10 size" : (r_in >= 8 ? "R3 size" : "R4 size");
      check(int'(size_o) == ns, zt, int'(size_o), ns);
      zt = (r_in >= 8) ? "R3 res" : "R4 res";
      check(int'(res_o) == nr, zt, int'(res_o), nr);
      check(int'(win_o) == nw, {tag, " win"}, int'(win_o), nw);
      zt = ((tag == "R5" && st_in == 0) || (tag == "R6" && st_in == MAXS)) ? "R8 stuff"
           : {tag, " stuff"};
      check(int'(stuff_o) == nst, zt, int'(stuff_o), nst);
      check(int'(edge_o) == e, "R9 edge", int'(edge_o), e);
      if (idle_check) begin
         win = DW'(w_in + 17); res = DW'(3); stuff = SW'(7);
         @(negedge clk);
         check(done_o === 1'b0, "R2 idle done", int'(done_o), 0);
         check(int'(size_o) == ns && int'(win_o) == nw && int'(stuff_o) == nst,
               "R2 hold", int'(win_o), nw);
      end
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL R2 watchdog expired: actual 0 expected 1");
         report();
      end
   end

   initial begin
      int stuffs[5] = '{0, 1, 30, 59, 60};
      repeat (3) @(negedge clk);
      // R1 reset state
      check(done_o === 1'b0 && size_o == 0 && res_o == 0 && win_o == 0
            && stuff_o == 0 && edge_o == 0, "R1 in reset", int'(edge_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(done_o === 1'b0 && size_o == 0 && res_o == 0 && win_o == 0
            && stuff_o == 0 && edge_o == 0, "R1 after release", int'(win_o), 0);
      // Named corner cases: R9 residual 4 and 0
      run_vec(0, 12, 5, 10, 1'b1);        // s=4 -> size 0 -> R5, res 4, edge F0
      check(int'(edge_o) == 8'hF0, "R9 res4", int'(edge_o), 8'hF0);
      run_vec(0, 40, 5, 10, 1'b1);        // s=32 -> size 4, res 0, edge FF
      check(int'(edge_o) == 8'hFF, "R9 res0", int'(edge_o), 8'hFF);
      // Sweep
      for (int r = -4; r <= 12; r++)
         for (int w = -24; w <= 120; w++)
            for (int k = 0; k < 5; k++)
               for (int z = 0; z < 2; z++)
                  run_vec(r, w, z * 9, stuffs[k], (w % 37 == 0));
      finished = 1;
      report();
   end
endmodule